// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination addresses for a single DMA channel while a transfer runs. A one-byte control word selects, for each side on its own, how the address moves on every transferred byte (held, counting up or counting down) and at which boundary it snaps back to its starting value (never, after each burst, after each block, or after the whole transaction). The bus engine that moves the data drives a per-beat advance strobe and boundary strobes for burst, block and transaction ends. The generator follows those strobes and presents the current addresses.

A two-state controller governs the channel. In CH_IDLE the control word may be rewritten, and a start request captures both programmed start addresses and takes the transition "start" into CH_BUSY. In CH_BUSY the control word is locked. The transaction-end strobe takes the transition "finish" back to CH_IDLE and raises the completion flag. An error takes the transition "abort" back to CH_IDLE and raises the error flag. Each flag is cleared by writing one to it. It raises an interrupt request when its programmable two-bit level is nonzero.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the control word, both addresses, both flags, both levels and both requests are zero and the channel is in CH_IDLE (busy low).
- R2: A control write in CH_IDLE stores the byte: source reload code in bits 7:6, source direction in bits 5:4, destination reload code in bits 3:2, destination direction in bits 1:0. It is visible on cfg_q one cycle later.
- R3: A control write while busy is ignored and cfg_q keeps its value.
- R4: ch_enable in CH_IDLE loads src_start and dst_start into the addresses and as reload values, and sets busy. While idle, the beat and boundary strobes leave the addresses unchanged. ch_enable while busy has no effect.
- R5: Direction code 01 adds one per beat and direction code 10 subtracts one per beat. Both wrap modulo 2^AW.
- R6: Direction code 00 and the reserved code 11 keep the address unchanged on a beat.
- R7: Reload code 01 restores the captured start value on block_end, 10 on burst_end, 11 on trn_end, and 00 never does. Other boundary strobes do not reload.
- R8: When a selected reload boundary and a beat occur in the same cycle, the address takes its captured start value.
- R9: trn_end while busy sets trn_flag and returns to CH_IDLE. err_in while busy sets err_flag and returns to CH_IDLE. Writing one in flag_clr bit 0 (completion) or bit 1 (error) clears that flag, and a set in the same cycle wins.
- R10: Each request is high exactly when its flag is set and its level is nonzero. The matching level output then shows the level and is 00 otherwise.
- R11: lvl_wdata bits 1:0 set the completion level and bits 3:2 set the error level. The levels may be written in either state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| lvl_we | input | 1 | Interrupt level write strobe |
| lvl_wdata | input | 4 | Error level [3:2], completion level [1:0] |
| src_start | input | AW | Programmed source start address |
| dst_start | input | AW | Programmed destination start address |
| ch_enable | input | 1 | Start request |
| beat | input | 1 | One byte transferred |
| burst_end | input | 1 | Burst boundary strobe |
| block_end | input | 1 | Block boundary strobe |
| trn_end | input | 1 | Transaction end strobe |
| err_in | input | 1 | Transfer error strobe |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Write-one-to-clear mask: bit 1 error, bit 0 completion |
| cfg_q | output | 8 | Stored control word |
| busy | output | 1 | Channel in CH_BUSY |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| trn_flag | output | 1 | Completion flag |
| err_flag | output | 1 | Error flag |
| trn_irq | output | 1 | Completion interrupt request |
| trn_irq_lvl | output | 2 | Level of the active completion request |
| err_irq | output | 1 | Error interrupt request |
| err_irq_lvl | output | 2 | Level of the active error request |

## Verification
Directed transfers pair opposite directions with different reload boundaries on the two sides. This separates a burst reload from a block reload and shows the sides act independently. Start addresses at the top and bottom of the range expose wrap errors, and the held and reserved direction codes show that no step leaks through. Coinciding beat and boundary strobes test the reload priority. Mid-transfer control writes, error aborts and level changes with a flag set test the lock and the request gating. A long random phase is compared cycle by cycle against a behavioural model to reach the other mixes of strobes.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    localparam logic [1:0] RLD_NONE  = 2'b00;
    localparam logic [1:0] RLD_BLOCK = 2'b01;
    localparam logic [1:0] RLD_BURST = 2'b10;
    localparam logic [1:0] RLD_TRANS = 2'b11;

    localparam logic [1:0] DIR_FIXED = 2'b00;
    localparam logic [1:0] DIR_INC   = 2'b01;
    localparam logic [1:0] DIR_DEC   = 2'b10;
    localparam logic [1:0] DIR_RSVD  = 2'b11;

    localparam int SIDE_CNT   = 2;
    localparam int SIDE_BITS  = 4;
    localparam int IRQ_CNT    = 2;
    localparam int LVL_BITS   = 2;
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
    import dma_ag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          active,
    input  logic          beat,
    input  logic          burst_end,
    input  logic          block_end,
    input  logic          trn_end,
    input  logic [1:0]    reload_mode,
    input  logic [1:0]    dir_mode,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] init_q;
    logic [AW-1:0] step_d;
    logic          boundary;
    logic          reload_hit;

    always_comb begin
        unique case (reload_mode)
            RLD_BLOCK: boundary = block_end;
            RLD_BURST: boundary = burst_end;
            RLD_TRANS: boundary = trn_end;
            default:   boundary = 1'b0;
        endcase
        reload_hit = active && boundary;
    end

    always_comb begin
        unique case (dir_mode)
            DIR_INC: step_d = addr + ONE;
            DIR_DEC: step_d = addr - ONE;
            default: step_d = addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            init_q <= '0;
        end else if (capture) begin
            addr   <= start;
            init_q <= start;
        end else if (reload_hit) begin
            addr   <= init_q;
        end else if (active && beat) begin
            addr   <= step_d;
        end
    end

    p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && beat && !reload_hit && dir_mode == DIR_INC) |=> addr == AW'($past(addr) + ONE));

    p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && beat && !reload_hit && dir_mode == DIR_DEC) |=> addr == AW'($past(addr) - ONE));

    p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !reload_hit && (dir_mode == DIR_FIXED || dir_mode == DIR_RSVD)) |=> $stable(addr));

    p_reload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_hit && beat) |=> addr == $past(init_q));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !capture) |=> $stable(addr));
endmodule

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
    import dma_ag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ch_enable,
    input  logic       trn_end,
    input  logic       err_in,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic       busy,
    output logic       capture,
    output logic       done_evt,
    output logic       err_evt,
    output logic [7:0] cfg_q
);
    ch_state_e state_q;
    ch_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ch_enable)          state_d = CH_BUSY;
            CH_BUSY: if (trn_end || err_in)  state_d = CH_IDLE;
            default:                         state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = 1'b0;
        capture  = 1'b0;
        done_evt = 1'b0;
        err_evt  = 1'b0;
        unique case (state_q)
            CH_IDLE: capture = ch_enable;
            CH_BUSY: begin
                busy     = 1'b1;
                done_evt = trn_end;
                err_evt  = err_in;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cfg_q <= '0;
        else if (cfg_we && !busy) cfg_q <= cfg_wdata;
    end

    p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q));

    p_cfg_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we) |=> cfg_q == $past(cfg_wdata));

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ch_enable) |=> busy);

    p_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (trn_end || err_in)) |=> !busy);
endmodule

// File: rtl/dma_ch_irq.sv
module dma_ch_irq
    import dma_ag_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         done_evt,
    input  logic                         err_evt,
    input  logic                         clr_we,
    input  logic [IRQ_CNT-1:0]           clr_mask,
    input  logic                         lvl_we,
    input  logic [IRQ_CNT*LVL_BITS-1:0]  lvl_wdata,
    output logic [IRQ_CNT-1:0]           flag,
    output logic [IRQ_CNT-1:0]           req,
    output logic [IRQ_CNT*LVL_BITS-1:0]  req_lvl
);
    logic [IRQ_CNT-1:0] evt;
    assign evt = {err_evt, done_evt};

    for (genvar g = 0; g < IRQ_CNT; g++) begin : g_src
        logic [LVL_BITS-1:0] lvl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        flag[g] <= 1'b0;
            else if (evt[g])                   flag[g] <= 1'b1;
            else if (clr_we && clr_mask[g])    flag[g] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      lvl_q <= '0;
            else if (lvl_we) lvl_q <= lvl_wdata[g*LVL_BITS +: LVL_BITS];
        end

        always_comb begin
            req[g] = flag[g] && (lvl_q != '0);
            req_lvl[g*LVL_BITS +: LVL_BITS] = req[g] ? lvl_q : '0;
        end

        p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag[g]);

        p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[g] && !evt[g]) |=> !flag[g]);

        p_req_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && !lvl_we && lvl_q != '0) |=> req[g]);
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          lvl_we,
    input  logic [3:0]    lvl_wdata,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic          ch_enable,
    input  logic          beat,
    input  logic          burst_end,
    input  logic          block_end,
    input  logic          trn_end,
    input  logic          err_in,
    input  logic          flag_clr_we,
    input  logic [1:0]    flag_clr,
    output logic [7:0]    cfg_q,
    output logic          busy,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          trn_flag,
    output logic          err_flag,
    output logic          trn_irq,
    output logic [1:0]    trn_irq_lvl,
    output logic          err_irq,
    output logic [1:0]    err_irq_lvl
);
    logic capture;
    logic done_evt;
    logic err_evt;
    logic [AW-1:0] start_arr [SIDE_CNT];
    logic [AW-1:0] addr_arr  [SIDE_CNT];
    logic [IRQ_CNT-1:0] flag_v;
    logic [IRQ_CNT-1:0] req_v;
    logic [IRQ_CNT*LVL_BITS-1:0] req_lvl_v;

    dma_ch_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_enable (ch_enable),
        .trn_end   (trn_end),
        .err_in    (err_in),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .capture   (capture),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .cfg_q     (cfg_q)
    );

    assign start_arr[0] = src_start;
    assign start_arr[1] = dst_start;

    for (genvar s = 0; s < SIDE_CNT; s++) begin : g_side
        localparam int HI = 8 - s * SIDE_BITS - 1;
        dma_addr_side #(.AW(AW)) u_side (
            .clk         (clk),
            .rst_n       (rst_n),
            .capture     (capture),
            .active      (busy),
            .beat        (beat),
            .burst_end   (burst_end),
            .block_end   (block_end),
            .trn_end     (trn_end),
            .reload_mode (cfg_q[HI -: 2]),
            .dir_mode    (cfg_q[HI-2 -: 2]),
            .start       (start_arr[s]),
            .addr        (addr_arr[s])
        );
    end

    assign src_addr = addr_arr[0];
    assign dst_addr = addr_arr[1];

    dma_ch_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .clr_we    (flag_clr_we),
        .clr_mask  (flag_clr),
        .lvl_we    (lvl_we),
        .lvl_wdata (lvl_wdata),
        .flag      (flag_v),
        .req       (req_v),
        .req_lvl   (req_lvl_v)
    );

    assign trn_flag    = flag_v[0];
    assign err_flag    = flag_v[1];
    assign trn_irq     = req_v[0];
    assign err_irq     = req_v[1];
    assign trn_irq_lvl = req_lvl_v[1:0];
    assign err_irq_lvl = req_lvl_v[3:2];

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ch_enable) |=> (src_addr == $past(src_start) && dst_addr == $past(dst_start)));
endmodule

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;
    localparam int AW = 16;
    localparam int MOD = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, lvl_we = 0, ch_enable = 0, beat = 0, burst_end = 0;
    logic block_end = 0, trn_end = 0, err_in = 0, flag_clr_we = 0;
    logic [7:0] cfg_wdata = '0;
    logic [3:0] lvl_wdata = '0;
    logic [1:0] flag_clr = '0;
    logic [AW-1:0] src_start = '0, dst_start = '0;
    logic [7:0] cfg_q;
    logic busy, trn_flag, err_flag, trn_irq, err_irq;
    logic [1:0] trn_irq_lvl, err_irq_lvl;
    logic [AW-1:0] src_addr, dst_addr;

    always #4 clk = ~clk;

    dma_addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .src_start(src_start),
        .dst_start(dst_start), .ch_enable(ch_enable), .beat(beat),
        .burst_end(burst_end), .block_end(block_end), .trn_end(trn_end),
        .err_in(err_in), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
        .cfg_q(cfg_q), .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr),
        .trn_flag(trn_flag), .err_flag(err_flag), .trn_irq(trn_irq),
        .trn_irq_lvl(trn_irq_lvl), .err_irq(err_irq), .err_irq_lvl(err_irq_lvl)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int m_cfg, m_busy, m_src, m_dst, m_src0, m_dst0, m_tf, m_ef, m_tl, m_el;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int side_next(int a, int a0, int rld, int dir, int st);
        bit hit;
        if (m_busy == 0) return (ch_enable) ? st : a;
        hit = (rld == 1 && block_end) || (rld == 2 && burst_end) || (rld == 3 && trn_end);
        if (hit) return a0;
        if (!beat) return a;
        if (dir == 1) return (a + 1) % MOD;
        if (dir == 2) return (a + MOD - 1) % MOD;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_busy = 0; m_src = 0; m_dst = 0; m_src0 = 0; m_dst0 = 0;
            m_tf = 0; m_ef = 0; m_tl = 0; m_el = 0;
            started = 1;
        end else begin
            int ns, nd, nb;
            ns = side_next(m_src, m_src0, (m_cfg >> 6) & 3, (m_cfg >> 4) & 3, int'(src_start));
            nd = side_next(m_dst, m_dst0, (m_cfg >> 2) & 3, m_cfg & 3, int'(dst_start));
            nb = m_busy;
            if (m_busy == 0 && ch_enable) begin
                m_src0 = int'(src_start); m_dst0 = int'(dst_start); nb = 1;
            end
            if (m_busy == 1) begin
                if (trn_end) m_tf = 1;
                else if (flag_clr_we && flag_clr[0]) m_tf = 0;
                if (err_in) m_ef = 1;
                else if (flag_clr_we && flag_clr[1]) m_ef = 0;
                if (trn_end || err_in) nb = 0;
            end else begin
                if (flag_clr_we && flag_clr[0]) m_tf = 0;
                if (flag_clr_we && flag_clr[1]) m_ef = 0;
            end
            if (cfg_we && m_busy == 0) m_cfg = int'(cfg_wdata);
            if (lvl_we) begin m_tl = int'(lvl_wdata[1:0]); m_el = int'(lvl_wdata[3:2]); end
            m_src = ns; m_dst = nd; m_busy = nb;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2/R3 cfg_q", int'(cfg_q), m_cfg);
            check("R4/R9 busy", int'(busy), m_busy);
            check("R5/R6/R7/R8 src_addr", int'(src_addr), m_src);
            check("R5/R6/R7/R8 dst_addr", int'(dst_addr), m_dst);
            check("R9 trn_flag", int'(trn_flag), m_tf);
            check("R9 err_flag", int'(err_flag), m_ef);
            check("R10 trn_irq", int'(trn_irq), (m_tf && m_tl != 0) ? 1 : 0);
            check("R10 err_irq", int'(err_irq), (m_ef && m_el != 0) ? 1 : 0);
            check("R10/R11 trn_irq_lvl", int'(trn_irq_lvl), (m_tf && m_tl != 0) ? m_tl : 0);
            check("R10/R11 err_irq_lvl", int'(err_irq_lvl), (m_ef && m_el != 0) ? m_el : 0);
        end
    end

    task automatic idle_strobes();
        cfg_we = 0; lvl_we = 0; ch_enable = 0; beat = 0; burst_end = 0;
        block_end = 0; trn_end = 0; err_in = 0; flag_clr_we = 0; flag_clr = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_strobes();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog R4 actual=hung expected=finished");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset cfg", int'(cfg_q), 0);
        check("R1 reset src", int'(src_addr), 0);
        check("R1 reset busy/irq", int'({busy, trn_flag, err_flag, trn_irq, err_irq}), 0);

        // R2 R11: src reload burst + inc, dst reload block + dec
        cfg_we = 1; cfg_wdata = 8'h96; lvl_we = 1; lvl_wdata = 4'b1001; tick();
        check("R2 cfg stored", int'(cfg_q), 8'h96);
        src_start = 16'h1000; dst_start = 16'h2000; ch_enable = 1; tick();
        check("R4 capture src", int'(src_addr), 16'h1000);
        check("R4 capture dst", int'(dst_addr), 16'h2000);
        for (int i = 0; i < 3; i++) begin beat = 1; tick(); end
        check("R5 inc", int'(src_addr), 16'h1003);
        check("R5 dec", int'(dst_addr), 16'h1FFD);
        beat = 1; burst_end = 1; tick();
        check("R8 reload beats step", int'(src_addr), 16'h1000);
        check("R7 burst leaves block side", int'(dst_addr), 16'h1FFC);
        beat = 1; block_end = 1; tick();
        check("R7 block reload dst", int'(dst_addr), 16'h2000);
        check("R7 block not src", int'(src_addr), 16'h1001);
        cfg_we = 1; cfg_wdata = 8'h00; tick();
        check("R3 locked", int'(cfg_q), 8'h96);
        ch_enable = 1; src_start = 16'h5555; tick();
        check("R4 enable ignored busy", int'(src_addr), 16'h1001);
        trn_end = 1; tick();
        check("R9 finish idle", int'(busy), 0);
        check("R10 trn irq lvl", int'(trn_irq_lvl), 1);
        beat = 1; burst_end = 1; tick();
        check("R4 idle hold", int'(src_addr), 16'h1001);
        flag_clr_we = 1; flag_clr = 2'b01; tick();
        check("R9 clear", int'(trn_flag), 0);

        // R6: reserved dir + transaction reload on src, fixed on dst
        cfg_we = 1; cfg_wdata = 8'hF0; tick();
        src_start = 16'h0042; dst_start = 16'h0050; ch_enable = 1; tick();
        for (int i = 0; i < 4; i++) begin beat = 1; tick(); end
        check("R6 reserved hold", int'(src_addr), 16'h0042);
        check("R6 fixed hold", int'(dst_addr), 16'h0050);
        trn_end = 1; tick();

        // R5 wrap, R7 code 00 never reloads
        cfg_we = 1; cfg_wdata = 8'h12; tick();
        src_start = 16'hFFFF; dst_start = 16'h0000; ch_enable = 1; tick();
        beat = 1; tick();
        check("R5 wrap up", int'(src_addr), 0);
        check("R5 wrap down", int'(dst_addr), 16'hFFFF);
        burst_end = 1; block_end = 1; tick();
        check("R7 none reload", int'(src_addr), 0);
        err_in = 1; tick();
        check("R9 abort", int'(busy), 0);
        check("R10 err lvl", int'(err_irq_lvl), 2);
        lvl_we = 1; lvl_wdata = 4'b0000; tick();
        check("R11 level off", int'(err_irq), 0);
        check("R9 flag kept", int'(err_flag), 1);
        flag_clr_we = 1; flag_clr = 2'b10; tick();

        // R7 transaction reload
        cfg_we = 1; cfg_wdata = 8'hD0; lvl_we = 1; lvl_wdata = 4'b1111; tick();
        src_start = 16'h0300; ch_enable = 1; tick();
        for (int i = 0; i < 5; i++) begin beat = 1; tick(); end
        beat = 1; trn_end = 1; tick();
        check("R7 trans reload", int'(src_addr), 16'h0300);
        check("R10 trn lvl 3", int'(trn_irq_lvl), 3);

        // random mix, compared each clock against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_we = ($urandom % 8) == 0; cfg_wdata = 8'($urandom);
            lvl_we = ($urandom % 16) == 0; lvl_wdata = 4'($urandom);
            ch_enable = ($urandom % 6) == 0;
            src_start = 16'($urandom); dst_start = 16'($urandom);
            beat = ($urandom % 2) == 0; burst_end = ($urandom % 5) == 0;
            block_end = ($urandom % 9) == 0; trn_end = ($urandom % 20) == 0;
            err_in = ($urandom % 40) == 0; flag_clr_we = ($urandom % 6) == 0;
            flag_clr = 2'($urandom);
        end
        tick();
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule